// File: doc/BRIEF.md
# Serial Binary-to-Decimal Digit Converter

This block turns an unsigned binary word of `IW` bits into packed binary-coded decimal. It works on one operand bit per clock. A single working register holds the growing decimal digits next to the unconsumed binary bits. On each step, every four-bit digit that holds five or more has three added to it, and then the whole register moves one place to the left. This way a digit carries into its neighbour at ten and not at sixteen. One shared adjust stage and one shifter serve the whole conversion.

A client presents an operand together with a start strobe while `busy_o` is low. The block then stays busy for `IW` cycles. After that it raises `valid_o` for exactly one cycle, and in that cycle the result may be captured. The digits stay on `bcd_o` until the next operand is loaded. The digit count is derived from `IW` and is the smallest number of decimal digits that can hold `2^IW - 1`.

Top module: `bin2bcd_serial`

## Requirements
- R1: The output carries `ND = floor(IW*log10(2)) + 1` digits, so it is `4*ND` bits wide. With the default `IW = 16` this is 5 digits in 20 bits.
- R2: While `rst_n` is low, and after it is released, `busy_o` and `valid_o` are 0 and `bcd_o` is all zeros.
- R3: A high `start_i` on a rising edge where `busy_o` is low loads `bin_i`. `busy_o` is then high for exactly `IW` consecutive cycles, starting in the cycle after that edge.
- R4: `valid_o` is high for exactly one cycle. That cycle is the first one after the busy run, which is the `IW+1`-th cycle after the load edge, and `busy_o` is low in it.
- R5: When `valid_o` is high, `bcd_o` equals the decimal value of the loaded operand. Digit k sits at bits `4k+3:4k`, with the least significant digit in bits 3:0. For example, input 100 gives `0x00100`.
- R6: When `valid_o` is high, every four-bit digit of `bcd_o` is in the range 0 to 9.
- R7: `start_i` and `bin_i` are ignored while `busy_o` is high. Neither the result nor the cycle of the valid pulse changes.
- R8: While `busy_o` is low and no load occurs, `bcd_o` holds its value.
- R9: A load is accepted in the same cycle in which `valid_o` is high, so conversions can run back to back.
- R10: The extreme operands convert correctly: 0 gives all-zero digits, and `2^IW - 1` gives 65535 (`0x65535`) at the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Load request, taken only while idle |
| bin_i | input | IW | Unsigned binary operand |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle strobe: result is ready |
| bcd_o | output | 4*ND | Packed decimal digits, least significant digit in the low nibble |

## Verification
The load edge is counted as edge 0. `busy_o` is due high after edge 0 and stays high through edge `IW-1`. `valid_o` and the final digits are due together after edge `IW`, and the pulse is gone after edge `IW+1`. The bench drives its stimulus on falling edges and samples on falling edges. Each task counts exactly that many falling edges from the load before it compares the outputs with a digit-by-digit division model. The ignored-load and back-to-back tasks check that these cycle counts stay the same under their stimulus.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } conv_state_e;

  // Decimal digits needed for the largest IW-bit value: floor(IW*log10 2) + 1
  function automatic int unsigned bcd_digits(input int unsigned width);
    return (width * 30103) / 100000 + 1;
  endfunction

endpackage

// File: rtl/bcd_nibble_adj.sv
module bcd_nibble_adj #(
  parameter int unsigned ND = 5
) (
  input  logic [4*ND-1:0] dig_i,
  output logic [4*ND-1:0] dig_o
);

  // A digit of five or more gets three added so the next shift carries at ten
  for (genvar g = 0; g < ND; g++) begin : g_nib
    logic [3:0] nib;
    assign nib = dig_i[4*g +: 4];
    assign dig_o[4*g +: 4] = (nib >= 4'd5) ? nib + 4'd3 : nib;
  end

endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl
  import bcd_pkg::*;
#(
  parameter int unsigned IW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic busy_o,
  output logic valid_o
);

  localparam int unsigned CW = $clog2(IW + 1);
  localparam logic [CW-1:0] STEPS = CW'(IW);

  conv_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          valid_q, valid_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    valid_d = 1'b0;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_RUN;
          cnt_d   = STEPS;
        end
      end
      ST_RUN: begin
        shift_o = 1'b1;
        cnt_d   = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          state_d = ST_IDLE;
          valid_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = load_o | shift_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o  = (state_q == ST_RUN);
  assign valid_o = valid_q;

endmodule

// File: rtl/bin2bcd_serial.sv
module bin2bcd_serial
  import bcd_pkg::*;
#(
  parameter int unsigned IW = 16,
  parameter int unsigned ND = bcd_digits(IW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [IW-1:0]   bin_i,
  output logic            busy_o,
  output logic            valid_o,
  output logic [4*ND-1:0] bcd_o
);

  localparam int unsigned OW = 4 * ND;
  localparam int unsigned WW = OW + IW;

  logic          load, shift, work_en;
  logic [OW-1:0] dig_adj;
  logic [WW-1:0] work_q, work_d;

  bcd_seq_ctrl #(.IW(IW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .shift_o (shift),
    .busy_o  (busy_o),
    .valid_o (valid_o)
  );

  bcd_nibble_adj #(.ND(ND)) u_adj (
    .dig_i (work_q[IW +: OW]),
    .dig_o (dig_adj)
  );

  always_comb begin
    work_d = work_q;
    if (load) begin
      work_d = {{OW{1'b0}}, bin_i};
    end else if (shift) begin
      work_d = {dig_adj, work_q[IW-1:0]} << 1;
    end
  end

  assign work_en = load | shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  assign bcd_o = work_q[IW +: OW];

endmodule

// File: rtl/bin2bcd_serial_chk.sv
module bin2bcd_serial_chk #(
  parameter int unsigned IW = 16,
  parameter int unsigned ND = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            valid_o,
  input logic [4*ND-1:0] bcd_o
);

  localparam int unsigned RW = $clog2(IW + 2);

  logic [RW-1:0] run_q;
  logic [ND-1:0] bad_dig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy_o) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  for (genvar g = 0; g < ND; g++) begin : g_dig
    assign bad_dig[g] = (bcd_o[4*g +: 4] > 4'd9);
  end

  p_load_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == RW'(IW)));

  p_valid_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> valid_o);

  p_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o);

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_digit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (bad_dig == '0));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(bcd_o));

endmodule

bind bin2bcd_serial bin2bcd_serial_chk #(.IW(IW), .ND(ND)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .valid_o (valid_o),
  .bcd_o   (bcd_o)
);

// File: tb/bin2bcd_serial_bench.sv
module bin2bcd_serial_bench;

  localparam int unsigned IW = 16;
  localparam int unsigned ND = 5;
  localparam int unsigned OW = 4 * ND;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [IW-1:0] bin_i;
  logic          busy_o;
  logic          valid_o;
  logic [OW-1:0] bcd_o;

  int tests_run;
  int tests_failed;
  bit finished;

  bin2bcd_serial #(.IW(IW)) u_bin2bcd_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .bin_i   (bin_i),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .bcd_o   (bcd_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [OW-1:0] model(input int unsigned v);
    logic [OW-1:0] r;
    int unsigned x;
    r = '0;
    x = v;
    for (int k = 0; k < ND; k++) begin
      r[4*k +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Edge 0 is the load edge; outputs sampled on falling edges after it.
  task automatic wait_run(input string req, output bit run_ok);
    run_ok = busy_o && !valid_o;        // after edge 0
    for (int k = 1; k < IW; k++) begin
      @(negedge clk);
      if (!(busy_o && !valid_o)) run_ok = 1'b0;
    end
    @(negedge clk);                     // after edge IW
  endtask

  task automatic convert(input int unsigned v, input string req);
    bit run_ok;
    @(negedge clk);
    start_i = 1'b1;
    bin_i   = IW'(v);
    @(negedge clk);
    start_i = 1'b0;
    bin_i   = '0;
    wait_run(req, run_ok);
    check(run_ok, "R3", 32'(busy_o), 32'd1);
    check(valid_o && !busy_o, "R4", {30'd0, valid_o, busy_o}, 32'h2);
    check(bcd_o == model(v), req, 32'(bcd_o), 32'(model(v)));
    check(bcd_o[3:0] <= 9 && bcd_o[7:4] <= 9 && bcd_o[11:8] <= 9 &&
          bcd_o[15:12] <= 9 && bcd_o[19:16] <= 9, "R6", 32'(bcd_o), 32'(model(v)));
    @(negedge clk);
    check(!valid_o, "R4", 32'(valid_o), 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    start_i = 1'b0;
    bin_i = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !valid_o && bcd_o == '0, "R2", 32'(bcd_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !valid_o && bcd_o == '0, "R2", {busy_o, valid_o, 10'd0, bcd_o}, 32'd0);
  endtask

  task automatic t_width;
    check($bits(bcd_o) == 20, "R1", 32'($bits(bcd_o)), 32'd20);
  endtask

  task automatic t_values;
    convert(100, "R5");
    convert(12345, "R5");
    convert(909, "R5");
    convert(0, "R10");
    convert(65535, "R10");
  endtask

  task automatic t_ignore_busy;
    bit run_ok;
    @(negedge clk);
    start_i = 1'b1;
    bin_i   = IW'(4321);
    @(negedge clk);
    start_i = 1'b0;
    run_ok = busy_o;
    repeat (3) @(negedge clk);
    start_i = 1'b1;                     // request while busy: ignored
    bin_i   = IW'(999);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 5; k < IW; k++) begin
      @(negedge clk);
      if (!busy_o) run_ok = 1'b0;
    end
    @(negedge clk);
    check(run_ok && valid_o, "R7", 32'(valid_o), 32'd1);
    check(bcd_o == model(4321), "R7", 32'(bcd_o), 32'(model(4321)));
    @(negedge clk);
  endtask

  task automatic t_hold;
    logic [OW-1:0] snap;
    convert(2468, "R5");
    snap = bcd_o;
    bin_i = IW'(777);                   // no start: must not disturb output
    repeat (5) @(negedge clk);
    check(bcd_o == snap && !busy_o, "R8", 32'(bcd_o), 32'(snap));
    bin_i = '0;
  endtask

  task automatic t_back_to_back;
    bit run_ok;
    @(negedge clk);
    start_i = 1'b1;
    bin_i   = IW'(58);
    @(negedge clk);
    start_i = 1'b0;
    wait_run("R9", run_ok);
    check(valid_o && bcd_o == model(58), "R9", 32'(bcd_o), 32'(model(58)));
    start_i = 1'b1;                     // load during the valid cycle
    bin_i   = IW'(30007);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o, "R9", 32'(busy_o), 32'd1);
    wait_run("R9", run_ok);
    check(run_ok && valid_o && bcd_o == model(30007), "R9", 32'(bcd_o),
          32'(model(30007)));
    @(negedge clk);
  endtask

  initial begin
    tests_run = 0;
    tests_failed = 0;
    finished = 1'b0;
    t_reset();
    t_width();
    t_values();
    t_ignore_busy();
    t_hold();
    t_back_to_back();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule